// File: doc/BRIEF.md
# Scatter-Gather Burst Mover

This block moves data between a host bus and on-chip segmentation and reassembly engines. A gather transfer reads a byte range from host memory and hands it to the engine as packed bus-width words. A scatter transfer takes packed words from the engine and writes them into a host byte range. The host range may start at any byte address. The mover always issues bursts at beat-aligned addresses. It shifts bytes across beat boundaries and drives partial byte enables at the edges of the range. A configuration input selects big-endian or little-endian host lane order, and both data and byte enables are reordered to match.

Two requesters share the mover, a control/status port and a data port, and only one transfer runs at a time. Each transfer is cut into bursts. The longest burst allowed depends on the request class and on the transfer direction. When the last byte has been moved, the mover pulses a completion output on the port that asked for the transfer. The requester holds its request and fields steady until that pulse and drops the request in the same cycle.

Top module: `sg_dma_mover`

## Requirements
- R1: After reset, bus_req, bus_wvalid, eng_rvalid, eng_rlast, eng_wpop, ctl_done and dat_done are all 0.
- R2: A gather transfer delivers host bytes [addr, addr+len) in order. Byte k sits in lane k mod B of engine word k div B, where lane i is bits 8i+7..8i and B is the bus width in bytes. Exactly ceil(len/B) words are delivered, and eng_rlast is high on the last word only.
- R3: Any byte offset of addr is accepted in both directions. Every bus_addr has its low log2(B) bits at 0, and the first burst starts at addr rounded down to a multiple of B.
- R4: A scatter transfer writes engine stream byte k (lane k mod B of the (k div B)-th popped word) to host byte addr+k for every k < len. Each write beat enables only lanes that fall inside the range, and every write beat enables at least one lane.
- R5: With cfg_big_endian=0, lane i of a beat at aligned address a is host byte a+i. With cfg_big_endian=1, lane i holds byte a+B-1-i. The same mapping applies to read data, write data and byte enables.
- R6: The longest burst is 14 beats for data reads, 12 beats for data writes and 4 beats for control/status transfers on a 4-byte bus (7, 6 and 2 on an 8-byte bus). A transfer uses ceil((addr mod B + len)/B) beats in total. Every burst except the last has the maximum length, and each burst starts at the address that follows the previous one.
- R7: bus_req, bus_addr and bus_len hold steady until bus_gnt is sampled high, and each grant starts exactly one burst.
- R8: Exactly one completion pulse appears per transfer, on ctl_done or on dat_done to match the port that was served. The pulse comes after the final beat, with no bus request or write beat in the same cycle.
- R9: When both requests are pending while the mover is idle, the control/status request is served first.
- R10: A request with len 0 completes without any bus request and without popping engine data.
- R11: A scatter transfer pulses eng_wpop exactly ceil(len/B) times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | 1 selects big-endian host lane order |
| ctl_req | input | 1 | Control/status transfer request, held until ctl_done |
| ctl_write | input | 1 | 1 = scatter (write host), 0 = gather (read host) |
| ctl_addr | input | AW | Host byte address of the control/status transfer |
| ctl_len | input | LW | Byte count of the control/status transfer |
| ctl_done | output | 1 | Completion pulse for the control/status port |
| dat_req | input | 1 | Data transfer request, held until dat_done |
| dat_write | input | 1 | 1 = scatter, 0 = gather |
| dat_addr | input | AW | Host byte address of the data transfer |
| dat_len | input | LW | Byte count of the data transfer |
| dat_done | output | 1 | Completion pulse for the data port |
| eng_rvalid | output | 1 | Packed gather word valid |
| eng_rlast | output | 1 | Final gather word of the transfer |
| eng_rdata | output | 8*BUS_BYTES | Packed gather word |
| eng_wdata | input | 8*BUS_BYTES | Head word of the engine's scatter stream |
| eng_wpop | output | 1 | Consume the head scatter word |
| bus_req | output | 1 | Burst request |
| bus_gnt | input | 1 | Burst grant |
| bus_write | output | 1 | Burst direction, 1 = write |
| bus_addr | output | AW | Beat-aligned burst start address |
| bus_len | output | 4 | Burst length in beats |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | 8*BUS_BYTES | Read beat data |
| bus_wvalid | output | 1 | Write beat valid |
| bus_wready | input | 1 | Write beat accepted |
| bus_wdata | output | 8*BUS_BYTES | Write beat data |
| bus_be | output | BUS_BYTES | Write beat byte enables |

## Verification
The hardest case to reach is a gather in which the final host beat holds the tail of the last engine word. There the mover must emit one extra word from its held beat after the bus has gone quiet, and only certain pairings of offset and length lead to it. The bench sweeps every byte offset against a set of lengths that mixes values just above and just below multiples of the bus width and of the burst caps. Each point is run in both directions, both classes and both lane orders. Grant delays and gaps in read-valid and write-ready are layered on top, so that the flush beat, a burst split and a stalled beat all occur in the same transfer.

// File: rtl/sg_dma_mover.sv
module sg_dma_mover #(
  parameter int BUS_BYTES = 4,
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_big_endian,
  input  logic                   ctl_req,
  input  logic                   ctl_write,
  input  logic [AW-1:0]          ctl_addr,
  input  logic [LW-1:0]          ctl_len,
  output logic                   ctl_done,
  input  logic                   dat_req,
  input  logic                   dat_write,
  input  logic [AW-1:0]          dat_addr,
  input  logic [LW-1:0]          dat_len,
  output logic                   dat_done,
  output logic                   eng_rvalid,
  output logic                   eng_rlast,
  output logic [BUS_BYTES*8-1:0] eng_rdata,
  input  logic [BUS_BYTES*8-1:0] eng_wdata,
  output logic                   eng_wpop,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   bus_write,
  output logic [AW-1:0]          bus_addr,
  output logic [3:0]             bus_len,
  input  logic                   bus_rvalid,
  input  logic [BUS_BYTES*8-1:0] bus_rdata,
  output logic                   bus_wvalid,
  input  logic                   bus_wready,
  output logic [BUS_BYTES*8-1:0] bus_wdata,
  output logic [BUS_BYTES-1:0]   bus_be
);
  localparam int DW = BUS_BYTES * 8;
  localparam int OB = $clog2(BUS_BYTES);
  localparam int CW = LW + 1;
  localparam int CAP_RD = (BUS_BYTES == 8) ? 7 : 14;
  localparam int CAP_WR = (BUS_BYTES == 8) ? 6 : 12;
  localparam int CAP_CS = (BUS_BYTES == 8) ? 2 : 4;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_FLUSH, S_DONE} st_t;

  st_t           st;
  logic          cls, wr;
  logic [OB-1:0] off;
  logic [LW-1:0] len;
  logic [AW-1:0] cur;
  logic [CW-1:0] beats_left, beat_idx, nwords;
  logic [3:0]    burst_left;
  logic [DW-1:0] prev;

  function automatic logic [DW-1:0] swap_d(input logic [DW-1:0] d);
    for (int i = 0; i < BUS_BYTES; i++) swap_d[8*i +: 8] = d[8*(BUS_BYTES-1-i) +: 8];
  endfunction

  function automatic logic [BUS_BYTES-1:0] swap_b(input logic [BUS_BYTES-1:0] b);
    for (int i = 0; i < BUS_BYTES; i++) swap_b[i] = b[BUS_BYTES-1-i];
  endfunction

  wire           pick_cs   = ctl_req;
  wire [AW-1:0]  req_addr  = pick_cs ? ctl_addr : dat_addr;
  wire [LW-1:0]  req_len   = pick_cs ? ctl_len : dat_len;
  wire           req_wr    = pick_cs ? ctl_write : dat_write;
  wire [OB-1:0]  req_off   = req_addr[OB-1:0];
  wire [CW-1:0]  req_beats = (CW'(req_off) + CW'(req_len) + CW'(BUS_BYTES - 1)) >> OB;
  wire [CW-1:0]  req_words = (CW'(req_len) + CW'(BUS_BYTES - 1)) >> OB;

  wire [3:0] cap = cls ? 4'(CAP_CS) : (wr ? 4'(CAP_WR) : 4'(CAP_RD));

  assign bus_req   = (st == S_ADDR);
  assign bus_write = wr;
  assign bus_addr  = cur;
  assign bus_len   = (beats_left < CW'(cap)) ? beats_left[3:0] : cap;
  assign ctl_done  = (st == S_DONE) && cls;
  assign dat_done  = (st == S_DONE) && !cls;

  // gather path: little-endian lane view of the incoming beat
  wire [DW-1:0]   rd     = cfg_big_endian ? swap_d(bus_rdata) : bus_rdata;
  wire [2*DW-1:0] rcat   = {rd, prev};
  wire [DW-1:0]   rshift = DW'(rcat >> {off, 3'b000});
  wire [DW-1:0]   fshift = prev >> {off, 3'b000};

  // scatter path
  wire [OB:0]     woff   = (OB+1)'(BUS_BYTES) - {1'b0, off};
  wire [2*DW-1:0] wcat   = {eng_wdata, prev};
  wire [DW-1:0]   wle    = DW'(wcat >> {woff, 3'b000});
  logic [BUS_BYTES-1:0] be_le;

  always_comb
    for (int l = 0; l < BUS_BYTES; l++)
      be_le[l] = (int'(beat_idx) * BUS_BYTES + l >= int'(off)) &&
                 (int'(beat_idx) * BUS_BYTES + l < int'(off) + int'(len));

  assign bus_wvalid = (st == S_DATA) && wr;
  assign bus_wdata  = cfg_big_endian ? swap_d(wle) : wle;
  assign bus_be     = cfg_big_endian ? swap_b(be_le) : be_le;

  wire rd_beat = (st == S_DATA) && !wr && bus_rvalid;
  wire wr_beat = (st == S_DATA) && wr && bus_wready;
  wire beat    = rd_beat || wr_beat;

  assign eng_wpop = wr_beat && (beat_idx < nwords);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cls <= 1'b0;
      wr <= 1'b0;
      off <= '0;
      len <= '0;
      cur <= '0;
      beats_left <= '0;
      beat_idx <= '0;
      nwords <= '0;
      burst_left <= '0;
      prev <= '0;
      eng_rvalid <= 1'b0;
      eng_rlast <= 1'b0;
      eng_rdata <= '0;
    end else begin
      eng_rvalid <= 1'b0;
      eng_rlast <= 1'b0;
      case (st)
        S_IDLE:
          if (ctl_req || dat_req) begin
            cls <= pick_cs;
            wr <= req_wr;
            off <= req_off;
            len <= req_len;
            cur <= {req_addr[AW-1:OB], {OB{1'b0}}};
            beats_left <= req_beats;
            nwords <= req_words;
            beat_idx <= '0;
            st <= (req_len == '0) ? S_DONE : S_ADDR;
          end
        S_ADDR:
          if (bus_gnt) begin
            burst_left <= bus_len;
            st <= S_DATA;
          end
        S_DATA:
          if (beat) begin
            cur <= cur + AW'(BUS_BYTES);
            beat_idx <= beat_idx + CW'(1);
            beats_left <= beats_left - CW'(1);
            burst_left <= burst_left - 4'd1;
            if (wr) begin
              if (eng_wpop) prev <= eng_wdata;
            end else begin
              prev <= rd;
              if (off == '0) begin
                eng_rvalid <= 1'b1;
                eng_rdata <= rd;
                eng_rlast <= (beat_idx == nwords - CW'(1));
              end else if (beat_idx != '0) begin
                eng_rvalid <= 1'b1;
                eng_rdata <= rshift;
                eng_rlast <= (beat_idx == nwords);
              end
            end
            if (beats_left == CW'(1))
              st <= (!wr && off != '0 && beat_idx + CW'(1) == nwords) ? S_FLUSH : S_DONE;
            else if (burst_left == 4'd1)
              st <= S_ADDR;
          end
        S_FLUSH: begin
          eng_rvalid <= 1'b1;
          eng_rdata <= fshift;
          eng_rlast <= 1'b1;
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_len));

  assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_len != 4'd0 &&
                (bus_write ? bus_len <= 4'(CAP_WR) : bus_len <= 4'(CAP_RD)) &&
                (!cls || bus_len <= 4'(CAP_CS)));

  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[OB-1:0] == '0);

  assert_be_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid |-> bus_be != '0);

  assert_last_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rlast |-> eng_rvalid);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done || dat_done) |-> !bus_req && !bus_wvalid && !(ctl_done && dat_done));
endmodule

// File: tb/test_sg_dma_mover.sv
module test_sg_dma_mover;
  localparam int B = 4, AW = 16, LW = 12, DW = 32;

  logic clk = 0, rst_n = 0, cfg_big_endian = 0;
  logic ctl_req = 0, ctl_write = 0, dat_req = 0, dat_write = 0;
  logic [AW-1:0] ctl_addr = '0, dat_addr = '0;
  logic [LW-1:0] ctl_len = '0, dat_len = '0;
  logic ctl_done, dat_done, eng_rvalid, eng_rlast, eng_wpop;
  logic [DW-1:0] eng_rdata, eng_wdata;
  logic bus_req, bus_gnt = 0, bus_write, bus_rvalid = 0, bus_wvalid, bus_wready = 0;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_len;
  logic [DW-1:0] bus_rdata = '0, bus_wdata;
  logic [B-1:0] bus_be;

  always #2.5 clk = ~clk;

  sg_dma_mover #(.BUS_BYTES(B), .AW(AW), .LW(LW)) i_sg_dma_mover (.*);

  int checks = 0, fails = 0;
  logic [7:0] mem [0:255];
  logic [7:0] ref0 [0:255];
  logic [7:0] src [0:127];
  logic [DW-1:0] rxw [0:255];
  logic rxl [0:255];
  int rx_total = 0, pop_total = 0, pop_base = 0, nb = 0;
  int bl [0:63];
  int ba [0:63];
  int stall_mode = 0, gdly = 0, cyc = 0, gwait = 0, rem = 0, haddr = 0;
  int g_len = 0, g_addr = 0;
  bit gave = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always_comb
    for (int l = 0; l < B; l++) eng_wdata[8*l +: 8] = src[((pop_total - pop_base) * B + l) & 127];

  always @(posedge clk) if (rst_n && eng_wpop) pop_total <= pop_total + 1;

  always @(negedge clk) if (rst_n && eng_rvalid) begin
    rxw[rx_total & 255] = eng_rdata;
    rxl[rx_total & 255] = eng_rlast;
    rx_total++;
  end

  // host bus model
  always @(negedge clk) begin
    cyc++;
    bus_gnt = 0; bus_rvalid = 0; bus_wready = 0;
    if (rst_n) begin
      if (gave) begin gave = 0; rem = g_len; haddr = g_addr; end
      if (rem > 0) begin
        if (!(stall_mode != 0 && (cyc % stall_mode) == 1)) begin
          if (bus_write) begin
            bus_wready = 1;
            for (int l = 0; l < B; l++)
              if (bus_be[l]) mem[cfg_big_endian ? haddr + B - 1 - l : haddr + l] = bus_wdata[8*l +: 8];
          end else begin
            bus_rvalid = 1;
            for (int l = 0; l < B; l++)
              bus_rdata[8*l +: 8] = mem[cfg_big_endian ? haddr + B - 1 - l : haddr + l];
          end
          haddr += B;
          rem--;
        end
      end else if (bus_req) begin
        if (gwait >= gdly) begin
          bus_gnt = 1; gave = 1; gwait = 0;
          g_len = int'(bus_len); g_addr = int'(bus_addr);
          bl[nb & 63] = g_len; ba[nb & 63] = g_addr; nb++;
        end else gwait++;
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!(ctl_done || dat_done));
  endtask

  task automatic xfer(bit cs, bit w, int addr, int len, bit big, int smode, int gd);
    int rx0, nb0, off, nbeats, nwords, cap, sum, bad, lastcnt, expb;
    bit gotc, gotd;
    string dtag;
    rx0 = rx_total; nb0 = nb; pop_base = pop_total;
    off = addr % B; nbeats = (off + len + B - 1) / B; nwords = (len + B - 1) / B;
    cap = cs ? 4 : (w ? 12 : 14);
    cfg_big_endian = big; stall_mode = smode; gdly = gd;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + len + addr); ref0[i] = mem[i]; end
    for (int i = 0; i < 128; i++) src[i] = 8'(i * 13 + addr * 3 + 1);
    if (cs) begin ctl_req = 1; ctl_write = w; ctl_addr = AW'(addr); ctl_len = LW'(len); end
    else begin dat_req = 1; dat_write = w; dat_addr = AW'(addr); dat_len = LW'(len); end
    wait_done();
    gotc = ctl_done; gotd = dat_done;
    ctl_req = 0; dat_req = 0;
    @(negedge clk);
    chk(cs ? (gotc && !gotd) : (gotd && !gotc), "R8", "completion on requesting port", int'(gotc), int'(cs));
    // R6 / R3 / R7: burst layout
    sum = 0; bad = 0;
    for (int k = nb0; k < nb; k++) begin
      if (bl[k & 63] > cap) bad++;
      if (k < nb - 1 && bl[k & 63] != cap) bad++;
      if (ba[k & 63] != (addr - off) + sum * B) bad++;
      sum += bl[k & 63];
    end
    chk(sum == nbeats, "R6", "total beats", sum, nbeats);
    chk(bad == 0, "R6", "burst cap/fill/contiguity violations", bad, 0);
    expb = (nbeats + cap - 1) / cap;
    chk(nb - nb0 == expb, "R7", "one burst per grant", nb - nb0, expb);
    chk(nb > nb0 && ba[nb0 & 63] == addr - off, "R3", "first burst address", nb > nb0 ? ba[nb0 & 63] : -1, addr - off);
    dtag = big ? "R5" : (off != 0 ? "R3" : (w ? "R4" : "R2"));
    if (!w) begin
      chk(rx_total - rx0 == nwords, "R2", "gather word count", rx_total - rx0, nwords);
      bad = 0; lastcnt = 0;
      for (int k = 0; k < len; k++)
        if (rxw[(rx0 + k / B) & 255][8*(k % B) +: 8] != ref0[addr + k]) bad++;
      for (int k = rx0; k < rx_total; k++) if (rxl[k & 255]) lastcnt++;
      chk(bad == 0, dtag, "gather byte mismatches", bad, 0);
      chk(lastcnt == 1 && rxl[(rx_total - 1) & 255], "R2", "eng_rlast count", lastcnt, 1);
    end else begin
      bad = 0;
      for (int i = 0; i < 256; i++)
        if (mem[i] != ((i >= addr && i < addr + len) ? src[i - addr] : ref0[i])) bad++;
      chk(bad == 0, dtag, "scatter host byte mismatches", bad, 0);
      chk(pop_total - pop_base == nwords, "R11", "engine pops", pop_total - pop_base, nwords);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R8 watchdog: actual 0 expected 1 completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lens [14] = '{1, 2, 3, 4, 5, 6, 8, 11, 16, 17, 31, 48, 56, 60};
    int rx0, nb0, p0;
    bit firstc;
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_wvalid && !eng_rvalid && !eng_rlast && !eng_wpop && !ctl_done && !dat_done,
        "R1", "outputs quiet in reset", int'(bus_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !eng_rvalid && !ctl_done && !dat_done, "R1", "outputs quiet after reset", int'(bus_req), 0);

    for (int big = 0; big < 2; big++)
      for (int w = 0; w < 2; w++)
        for (int cs = 0; cs < 2; cs++)
          for (int off = 0; off < B; off++)
            for (int li = 0; li < 14; li++)
              xfer(cs[0], w[0], 40 + off + (lens[li] % 2) * 8, lens[li], big[0],
                   (lens[li] % 3 == 0) ? 5 : ((lens[li] % 3 == 1) ? 0 : 3), off % 3);

    // R9: both requests pending together
    rx0 = rx_total; nb0 = nb;
    cfg_big_endian = 0; stall_mode = 0; gdly = 1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    ctl_req = 1; ctl_write = 0; ctl_addr = AW'(100); ctl_len = LW'(8);
    dat_req = 1; dat_write = 0; dat_addr = AW'(40); dat_len = LW'(20);
    wait_done();
    firstc = ctl_done;
    ctl_req = 0;
    chk(firstc, "R9", "control served first", int'(firstc), 1);
    chk(ba[nb0 & 63] == 100, "R9", "first burst address", ba[nb0 & 63], 100);
    wait_done();
    chk(dat_done, "R9", "data served second", int'(dat_done), 1);
    dat_req = 0;
    @(negedge clk);
    chk(rx_total - rx0 == 7, "R9", "words from both transfers", rx_total - rx0, 7);
    chk(rxw[rx0 & 255] == 32'h67666564, "R9", "first word from control range", int'(rxw[rx0 & 255]), 32'h67666564);

    // R10: zero length
    nb0 = nb; p0 = pop_total;
    dat_req = 1; dat_write = 1; dat_addr = AW'(45); dat_len = '0;
    wait_done();
    dat_req = 0;
    @(negedge clk);
    chk(nb == nb0, "R10", "no burst for zero length", nb - nb0, 0);
    chk(pop_total == p0, "R10", "no pop for zero length", pop_total - p0, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule